// File: doc/BRIEF.md
# Clear-on-Read Event Statistics Counters

This block is a bank of event counters for an Ethernet MAC. Each counter has one event input. A one-cycle pulse on that input adds exactly one to the counter. The CPU side reads any counter through a plain strobe-and-select port. The read returns the counter's value and clears the counter in the same clock edge, so there is no window in which an event can fall between a read and a later clear. If an event for the selected counter arrives in the same cycle as its read, that event is kept in the freshly cleared counter.

An external reset-in-progress flag blocks reads. While the flag is high, a strobe is refused: no valid data comes back and no counter is cleared, but counting goes on. Read results are registered. The read port has no back-pressure. A strobe is either accepted or refused in its own cycle, and the result appears on the cycle after it, flagged by a one-cycle valid pulse. The reader must take the result in that cycle, because the port cannot stall.

Top module: `evt_stat_bank`

## Requirements
- R1: A synchronous reset clears every counter to zero and drives `rd_valid` and `rd_data` to zero, even while events are pulsing.
- R2: Each counter grows by exactly one in every cycle its own event bit is high, and it is unaffected by the other event bits.
- R3: A strobe with `rd_busy` low is accepted. In the next cycle `rd_valid` is 1 and `rd_data` holds the selected counter's value as it stood at the strobe.
- R4: An accepted read clears the selected counter, so a second read with no events in between returns 0.
- R5: When the selected counter's event and its accepted read share a cycle, the read returns the old value and the counter then holds 1.
- R6: A strobe while `rd_busy` is 1 is refused. In the next cycle `rd_valid` is 0 and `rd_data` is 0, the counter keeps its value, and it keeps counting.
- R7: An accepted read with `rd_sel` from 5 to 7 gives `rd_valid` 1 and `rd_data` 0, and it clears or changes no counter.
- R8: A counter at its all-ones value wraps to 0 on its next event, without saturating.
- R9: There are five counters, each 32 bits wide, selected by `rd_sel` values 0 to 4. Counter k counts `evt[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt | input | 5 | Event pulses, one bit per counter |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_sel | input | 3 | Counter index for the read |
| rd_busy | input | 1 | Reset-in-progress flag; refuses reads while high |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries an accepted read |

## Verification
On every cycle, the assertions check these behaviours:
- an accepted read raises `rd_valid` one cycle later and returns the counter value sampled at the strobe;
- a refused read leaves the outputs at zero;
- spare selects return zero;
- a cleared counter holds only the coincident event;
- a counter with neither event nor read stays unchanged.

Only the bench's scenarios can show the following:
- that the counts add up over a series of events on several counters at once;
- that a blocked read leaves the count intact for a later read;
- that a spare select leaves every counter untouched;
- that the count wraps after the full range. The wrap is shown on a narrowed instance.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STAT_NUM_DEF   = 5;
  localparam int STAT_WIDTH_DEF = 32;
  localparam int STAT_SEL_DEF   = 3;

  function automatic int sel_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= evt ? ONE : '0;
    else if (evt)  cnt <= cnt + ONE;
  end

  AST_CLEAR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == ($past(evt) ? ONE : '0)));            // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr && !evt) |=> $stable(cnt));                     // R2
endmodule

// File: rtl/stat_rdport.sv
module stat_rdport #(
  parameter int N  = 5,
  parameter int W  = 32,
  parameter int SW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stb,
  input  logic                busy,
  input  logic [SW-1:0]       sel,
  input  logic [N-1:0][W-1:0] cnt_bus,
  output logic [N-1:0]        clr_vec,
  output logic [W-1:0]        rd_data,
  output logic                rd_valid
);
  logic         accept;
  logic [W-1:0] pick;

  assign accept = stb && !busy;

  always_comb begin
    pick    = '0;
    clr_vec = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(sel) == i) begin
        pick       = cnt_bus[i];
        clr_vec[i] = accept;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= accept;
      rd_data  <= accept ? pick : '0;
    end
  end

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_vec));                                   // R4
endmodule

// File: rtl/evt_stat_bank.sv
module evt_stat_bank
  import stat_pkg::*;
#(
  parameter int N_CNT = STAT_NUM_DEF,
  parameter int CNT_W = STAT_WIDTH_DEF,
  parameter int SEL_W = STAT_SEL_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CNT-1:0] evt,
  input  logic             rd_stb,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic             rd_busy,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid
);
  localparam int NEED_SEL = sel_bits(N_CNT);

  logic [N_CNT-1:0][CNT_W-1:0] cnt_bus;
  logic [N_CNT-1:0]            clr_vec;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    stat_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .evt (evt[g]),
      .clr (clr_vec[g]),
      .cnt (cnt_bus[g])
    );
  end

  stat_rdport #(.N(N_CNT), .W(CNT_W), .SW(SEL_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .stb      (rd_stb),
    .busy     (rd_busy),
    .sel      (rd_sel),
    .cnt_bus  (cnt_bus),
    .clr_vec  (clr_vec),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  initial begin
    AST_SEL_WIDE: assert (SEL_W >= NEED_SEL);             // R9
  end

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_busy) |=> rd_valid);                   // R3
  AST_DATA_SAMPLED: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_busy && int'(rd_sel) < N_CNT)
      |=> rd_data == $past(cnt_bus[rd_sel]));             // R3
  AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (rst)
    rd_busy |=> (!rd_valid && rd_data == '0));            // R6
  AST_SPARE_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_busy && int'(rd_sel) >= N_CNT) |=> rd_data == '0); // R7
endmodule

// File: tb/sim_evt_stat_bank.sv
`timescale 1ns/1ps
module sim_evt_stat_bank;
  typedef struct packed {
    logic [4:0]  evt;
    logic        stb;
    logic        busy;
    logic [2:0]  sel;
    logic        exp_v;
    logic [31:0] exp_d;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{5'b00001, 1'b0, 1'b0, 3'd0, 1'b0, 32'd0},  // R2
    '{5'b00011, 1'b0, 1'b0, 3'd0, 1'b0, 32'd0},  // R2
    '{5'b10101, 1'b0, 1'b0, 3'd0, 1'b0, 32'd0},  // R2
    '{5'b00000, 1'b1, 1'b0, 3'd0, 1'b1, 32'd3},  // R3
    '{5'b00000, 1'b1, 1'b0, 3'd0, 1'b1, 32'd0},  // R4
    '{5'b00010, 1'b1, 1'b0, 3'd1, 1'b1, 32'd1},  // R5
    '{5'b00000, 1'b1, 1'b0, 3'd1, 1'b1, 32'd1},  // R5
    '{5'b00100, 1'b1, 1'b1, 3'd2, 1'b0, 32'd0},  // R6
    '{5'b00000, 1'b1, 1'b0, 3'd2, 1'b1, 32'd2},  // R6
    '{5'b11111, 1'b1, 1'b0, 3'd5, 1'b1, 32'd0},  // R7
    '{5'b00000, 1'b1, 1'b0, 3'd7, 1'b1, 32'd0},  // R7
    '{5'b00000, 1'b1, 1'b0, 3'd4, 1'b1, 32'd2},  // R7 R9
    '{5'b00000, 1'b1, 1'b0, 3'd3, 1'b1, 32'd1},  // R9
    '{5'b00000, 1'b1, 1'b0, 3'd0, 1'b1, 32'd1}   // R9
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  evt = '0;
  logic        rd_stb = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic        rd_busy = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [4:0]  w_evt = '0;
  logic        w_stb = 1'b0;
  logic [2:0]  w_sel = '0;
  logic [3:0]  w_data;
  logic        w_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  evt_stat_bank u0 (
    .clk(clk), .rst(rst), .evt(evt), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .rd_busy(rd_busy), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  evt_stat_bank #(.CNT_W(4)) u1 (
    .clk(clk), .rst(rst), .evt(w_evt), .rd_stb(w_stb), .rd_sel(w_sel),
    .rd_busy(1'b0), .rd_data(w_data), .rd_valid(w_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 valid after reset", 32'(rd_valid), 32'd0);
    chk("R1 data after reset", rd_data, 32'd0);

    for (int i = 0; i < NV; i++) begin
      evt = VEC[i].evt; rd_stb = VEC[i].stb; rd_busy = VEC[i].busy; rd_sel = VEC[i].sel;
      @(negedge clk);
      chk($sformatf("R3-table step %0d valid", i), 32'(rd_valid), 32'(VEC[i].exp_v));
      chk($sformatf("R3-table step %0d data", i), rd_data, VEC[i].exp_d);
    end
    evt = '0; rd_stb = 1'b0;

    // R1: reset wins over events
    evt = 5'b11111;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; evt = '0;
    for (int k = 0; k < 5; k++) begin
      rd_stb = 1'b1; rd_sel = 3'(k);
      @(negedge clk);
      chk($sformatf("R1 counter %0d cleared", k), rd_data, 32'd0);
    end
    rd_stb = 1'b0;

    // R8: wrap on 4-bit instance
    w_evt = 5'b00001;
    repeat (15) @(negedge clk);
    w_evt = '0; w_stb = 1'b1; w_sel = 3'd0;
    @(negedge clk);
    chk("R8 all-ones before wrap", 32'(w_data), 32'd15);
    w_stb = 1'b0; w_evt = 5'b00001;
    repeat (16) @(negedge clk);
    w_evt = '0; w_stb = 1'b1;
    @(negedge clk);
    chk("R8 wrapped to zero", 32'(w_data), 32'd0);
    w_stb = 1'b0; w_evt = 5'b00001;
    repeat (17) @(negedge clk);
    w_evt = '0; w_stb = 1'b1;
    @(negedge clk);
    chk("R8 wrap then one", 32'(w_data), 32'd1);
    w_stb = 1'b0;

    finish_run();
  end
endmodule